// File: doc/BRIEF.md
# Path-Tagged Trace Segment Store

This block keeps recently retired instruction paths as trace segments in a direct-mapped table, so that a fetch stage can pick up a whole multi-block run of instructions in one access. The fill side receives instructions from retirement, one per cycle. Each one carries its address, its encoding, a conditional-branch marker, the resolved direction and the branch target. The fill side appends them to a line buffer. When the buffer holds a full line of instructions, or the newest instruction is the last branch a segment may contain, the segment is closed and written to the table. The next retired instruction then opens a fresh segment.

The lookup side takes a fetch address and the predicted directions of the branches inside the segment. The low address bits select a table slot. A hit requires three things: the slot is valid, the upper address bits match the stored tag, and the predicted directions agree with the recorded directions. Only the directions of branches that are followed by more instructions in the segment take part in that comparison. On a hit the block returns the instructions, the length, the terminal-branch flag, and the fall-through and target addresses of the segment.

Top module: `trace_seg_store`

## Requirements
- R1: After reset every slot is invalid. Every lookup misses, and `rsp_valid` and `rsp_hit` are low until a lookup has been made.
- R2: A lookup sampled at clock edge k produces exactly one response with `rsp_valid` high, visible after edge k+2. No response appears without a lookup.
- R3: A lookup whose address selects a valid slot but whose upper address bits (above the 6 index bits) differ from the stored start address misses.
- R4: `lk_pred` bit i is the predicted direction of the i-th branch in the segment (1 = taken). Bit i is compared only if branch i is followed by at least one more instruction in the same segment. Any difference in a compared bit gives a miss. Uncompared bits are ignored.
- R5: On a hit, `rsp_len` gives the instruction count (1 to 16). Slot j of `rsp_insns` (bits 32*j+31 down to 32*j) holds the j-th retired instruction of the segment. Slots at or above the length read as zero.
- R6: A segment closes after its 16th instruction when it holds fewer than 3 branches.
- R7: A segment closes at its 3rd conditional branch, whatever its length.
- R8: The fall-through address is the address of the segment's last instruction plus one. If the last instruction is a branch, the target is that branch's retired target, whether it was taken or not, and `rsp_end_br` is 1. Otherwise the target equals the fall-through address and `rsp_end_br` is 0.
- R9: The instruction retired right after a segment closes becomes the first instruction, and the start address, of the next segment.
- R10: Writing a segment to an occupied slot replaces the old one. The old start address then misses.
- R11: A lookup sampled on the same edge at which a segment is written to the slot it selects returns the slot's previous contents.
- R12: On a miss, `rsp_len`, `rsp_insns`, `rsp_fall`, `rsp_tgt` and `rsp_end_br` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address (instruction granular) |
| lk_pred | input | 2 | Predicted directions, bit i = branch i |
| rt_valid | input | 1 | Retired instruction present |
| rt_pc | input | 32 | Address of the retired instruction |
| rt_insn | input | 32 | Encoding of the retired instruction |
| rt_is_br | input | 1 | Retired instruction is a conditional branch |
| rt_taken | input | 1 | Resolved direction of that branch |
| rt_target | input | 32 | Target address of that branch |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_len | output | 5 | Segment length in instructions |
| rsp_insns | output | 512 | Segment instructions, slot 0 in the low bits |
| rsp_end_br | output | 1 | Last instruction is a conditional branch |
| rsp_fall | output | 32 | Fall-through address |
| rsp_tgt | output | 32 | Target address |

## Verification
A segment write and a lookup of the same slot can land on the same clock edge. That happens when the fetch side probes a start address while the fill side is closing a segment that maps to that slot. The bench closes a segment whose slot already holds an older path, and it issues a lookup of the older path in the very next cycle. It expects the older path's full contents to come back. The two lookups that follow are expected to hit the new segment and miss the displaced one.

// File: rtl/tseg_pkg.sv
package tseg_pkg;
  localparam int unsigned TS_ADDR_W  = 32;
  localparam int unsigned TS_INSN_W  = 32;
  localparam int unsigned TS_SEG_LEN = 16;
  localparam int unsigned TS_MAX_BR  = 3;
  localparam int unsigned TS_ENTRIES = 64;

  localparam int unsigned TS_IDX_W = $clog2(TS_ENTRIES);
  localparam int unsigned TS_TAG_W = TS_ADDR_W - TS_IDX_W;
  localparam int unsigned TS_FLG_W = TS_MAX_BR - 1;
  localparam int unsigned TS_LEN_W = $clog2(TS_SEG_LEN + 1);
  localparam int unsigned TS_BRC_W = $clog2(TS_MAX_BR + 1);

  typedef struct packed {
    logic [TS_SEG_LEN-1:0][TS_INSN_W-1:0] insns;
    logic [TS_TAG_W-1:0]  tag;
    logic [TS_FLG_W-1:0]  flags;
    logic [TS_FLG_W-1:0]  mask;
    logic                 end_br;
    logic [TS_LEN_W-1:0]  len;
    logic [TS_ADDR_W-1:0] fall;
    logic [TS_ADDR_W-1:0] tgt;
  } seg_t;

  // Thermometer mask with the n lowest bits set.
  function automatic logic [TS_FLG_W-1:0] low_mask(input logic [TS_BRC_W-1:0] n);
    logic [TS_FLG_W-1:0] m;
    for (int i = 0; i < TS_FLG_W; i++) m[i] = (TS_BRC_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/tseg_fill.sv
module tseg_fill
  import tseg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rt_valid,
  input  logic [TS_ADDR_W-1:0] rt_pc,
  input  logic [TS_INSN_W-1:0] rt_insn,
  input  logic                 rt_is_br,
  input  logic                 rt_taken,
  input  logic [TS_ADDR_W-1:0] rt_target,
  output logic                 wr_en,
  output logic [TS_IDX_W-1:0]  wr_idx,
  output seg_t                 wr_seg
);
  localparam logic [TS_LEN_W-1:0] LEN_LIM = TS_LEN_W'(TS_SEG_LEN);
  localparam logic [TS_BRC_W-1:0] BR_LIM  = TS_BRC_W'(TS_MAX_BR);

  logic [TS_SEG_LEN-1:0][TS_INSN_W-1:0] buf_q, merged;
  logic [TS_LEN_W-1:0]  cnt_q, cnt_n;
  logic [TS_BRC_W-1:0]  brc_q, brc_n;
  logic [TS_FLG_W-1:0]  flg_q, flg_n;
  logic [TS_ADDR_W-1:0] start_q, start_pc, fall_pc;
  logic                 seg_done;

  // Line buffer with the incoming instruction merged in; unused slots zero.
  for (genvar g = 0; g < TS_SEG_LEN; g++) begin : g_slot
    assign merged[g] = (TS_LEN_W'(g) < cnt_q)  ? buf_q[g] :
                       (TS_LEN_W'(g) == cnt_q) ? rt_insn  : '0;
  end

  always_comb begin
    cnt_n    = cnt_q + 1'b1;
    brc_n    = brc_q + TS_BRC_W'(rt_is_br);
    seg_done = rt_valid && ((cnt_n == LEN_LIM) || (rt_is_br && brc_n == BR_LIM));
    start_pc = (cnt_q == '0) ? rt_pc : start_q;
    fall_pc  = rt_pc + TS_ADDR_W'(1);
    flg_n    = flg_q;
    for (int i = 0; i < TS_FLG_W; i++)
      if (rt_is_br && brc_q == TS_BRC_W'(i)) flg_n[i] = rt_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      brc_q   <= '0;
      flg_q   <= '0;
      start_q <= '0;
      buf_q   <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_seg  <= '0;
    end else begin
      wr_en <= seg_done;
      if (rt_valid) begin
        buf_q <= merged;
        if (seg_done) begin
          cnt_q         <= '0;
          brc_q         <= '0;
          flg_q         <= '0;
          wr_idx        <= start_pc[TS_IDX_W-1:0];
          wr_seg.insns  <= merged;
          wr_seg.tag    <= start_pc[TS_ADDR_W-1:TS_IDX_W];
          wr_seg.flags  <= flg_n;
          // Branches already buffered are all followed by this instruction.
          wr_seg.mask   <= low_mask(brc_q);
          wr_seg.end_br <= rt_is_br;
          wr_seg.len    <= cnt_n;
          wr_seg.fall   <= fall_pc;
          wr_seg.tgt    <= rt_is_br ? rt_target : fall_pc;
        end else begin
          cnt_q   <= cnt_n;
          brc_q   <= brc_n;
          flg_q   <= flg_n;
          start_q <= start_pc;
        end
      end
    end
  end

  // R6: the open line never holds a full segment's worth of instructions.
  a_r6_open_len_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < LEN_LIM);
  // R7: the open line never holds the branch limit.
  a_r7_open_br_bound: assert property (@(posedge clk) disable iff (rst)
    brc_q < BR_LIM);
  // R9: a closed segment leaves an empty line behind.
  a_r9_restart_empty: assert property (@(posedge clk) disable iff (rst)
    seg_done |=> (cnt_q == '0 && brc_q == '0 && wr_en));
endmodule

// File: rtl/tseg_array.sv
module tseg_array
  import tseg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [TS_IDX_W-1:0] wr_idx,
  input  seg_t                wr_seg,
  input  logic [TS_IDX_W-1:0] rd_idx,
  output seg_t                rd_seg,
  output logic                rd_vld
);
  seg_t                  mem [TS_ENTRIES];
  logic [TS_ENTRIES-1:0] vld_q;

  // Read-before-write payload store, no reset: maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_seg;
    rd_seg <= mem[rd_idx];
  end

  // Valid bits live in flops so reset can clear them in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      rd_vld <= vld_q[rd_idx];
    end
  end
endmodule

// File: rtl/tseg_match.sv
module tseg_match
  import tseg_pkg::*;
(
  input  logic                vld,
  input  logic [TS_TAG_W-1:0] ent_tag,
  input  logic [TS_FLG_W-1:0] ent_flags,
  input  logic [TS_FLG_W-1:0] ent_mask,
  input  logic [TS_TAG_W-1:0] req_tag,
  input  logic [TS_FLG_W-1:0] req_pred,
  output logic                hit
);
  logic [TS_FLG_W-1:0] diff;
  always_comb begin
    diff = (req_pred ^ ent_flags) & ent_mask;
    hit  = vld && (req_tag == ent_tag) && (diff == '0);
  end
endmodule

// File: rtl/trace_seg_store.sv
module trace_seg_store
  import tseg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lk_valid,
  input  logic [TS_ADDR_W-1:0]             lk_addr,
  input  logic [TS_FLG_W-1:0]              lk_pred,
  input  logic                             rt_valid,
  input  logic [TS_ADDR_W-1:0]             rt_pc,
  input  logic [TS_INSN_W-1:0]             rt_insn,
  input  logic                             rt_is_br,
  input  logic                             rt_taken,
  input  logic [TS_ADDR_W-1:0]             rt_target,
  output logic                             rsp_valid,
  output logic                             rsp_hit,
  output logic [TS_LEN_W-1:0]              rsp_len,
  output logic [TS_SEG_LEN*TS_INSN_W-1:0]  rsp_insns,
  output logic                             rsp_end_br,
  output logic [TS_ADDR_W-1:0]             rsp_fall,
  output logic [TS_ADDR_W-1:0]             rsp_tgt
);
  logic                wr_en;
  logic [TS_IDX_W-1:0] wr_idx;
  seg_t                wr_seg, rd_seg;
  logic                rd_vld, hit;
  logic                s1_valid;
  logic [TS_TAG_W-1:0] s1_tag;
  logic [TS_FLG_W-1:0] s1_pred;

  tseg_fill u_fill (
    .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_insn(rt_insn),
    .rt_is_br(rt_is_br), .rt_taken(rt_taken), .rt_target(rt_target),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_seg(wr_seg)
  );

  tseg_array u_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_seg(wr_seg),
    .rd_idx(lk_addr[TS_IDX_W-1:0]), .rd_seg(rd_seg), .rd_vld(rd_vld)
  );

  tseg_match u_match (
    .vld(rd_vld), .ent_tag(rd_seg.tag), .ent_flags(rd_seg.flags),
    .ent_mask(rd_seg.mask), .req_tag(s1_tag), .req_pred(s1_pred), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_tag     <= '0;
      s1_pred    <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_len    <= '0;
      rsp_insns  <= '0;
      rsp_end_br <= 1'b0;
      rsp_fall   <= '0;
      rsp_tgt    <= '0;
    end else begin
      s1_valid  <= lk_valid;
      s1_tag    <= lk_addr[TS_ADDR_W-1:TS_IDX_W];
      s1_pred   <= lk_pred;
      rsp_valid <= s1_valid;
      rsp_hit   <= s1_valid && hit;
      if (s1_valid && hit) begin
        rsp_len    <= rd_seg.len;
        rsp_insns  <= rd_seg.insns;
        rsp_end_br <= rd_seg.end_br;
        rsp_fall   <= rd_seg.fall;
        rsp_tgt    <= rd_seg.tgt;
      end else begin
        rsp_len    <= '0;
        rsp_insns  <= '0;
        rsp_end_br <= 1'b0;
        rsp_fall   <= '0;
        rsp_tgt    <= '0;
      end
    end
  end

  // R2: every lookup yields a response two edges later.
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 rsp_valid);
  // R1: a hit is only ever reported inside a response.
  a_r1_hit_in_resp: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  // R5: a hit carries a legal, non-empty length.
  a_r5_hit_len: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_len != '0 && rsp_len <= TS_LEN_W'(TS_SEG_LEN)));
endmodule

// File: tb/trace_seg_store_tb.sv
module trace_seg_store_tb;
  typedef struct packed {
    logic         hit;
    logic [4:0]   len;
    logic         end_br;
    logic [31:0]  fall;
    logic [31:0]  tgt;
    logic [511:0] ins;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lk_valid = 1'b0;
  logic [31:0]  lk_addr = '0;
  logic [1:0]   lk_pred = '0;
  logic         rt_valid = 1'b0;
  logic [31:0]  rt_pc = '0;
  logic [31:0]  rt_insn = '0;
  logic         rt_is_br = 1'b0;
  logic         rt_taken = 1'b0;
  logic [31:0]  rt_target = '0;
  logic         rsp_valid, rsp_hit, rsp_end_br;
  logic [4:0]   rsp_len;
  logic [511:0] rsp_insns;
  logic [31:0]  rsp_fall, rsp_tgt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [511:0] acc = '0;
  int           acc_len = 0;

  always #5 clk = ~clk;

  trace_seg_store u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_pred(lk_pred),
    .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_insn(rt_insn), .rt_is_br(rt_is_br),
    .rt_taken(rt_taken), .rt_target(rt_target), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_len(rsp_len), .rsp_insns(rsp_insns),
    .rsp_end_br(rsp_end_br), .rsp_fall(rsp_fall), .rsp_tgt(rsp_tgt)
  );

  function automatic logic [31:0] ins_of(input logic [31:0] pc);
    return {8'hC3, pc[23:0]};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rt_valid = 1'b0;
      lk_valid = 1'b0;
    end
  endtask

  task automatic retire(input logic [31:0] pc, input logic br, input logic tk,
                        input logic [31:0] tg);
    @(negedge clk);
    lk_valid  = 1'b0;
    rt_valid  = 1'b1;
    rt_pc     = pc;
    rt_insn   = ins_of(pc);
    rt_is_br  = br;
    rt_taken  = tk;
    rt_target = tg;
    acc[acc_len*32 +: 32] = ins_of(pc);
    acc_len++;
  endtask

  // Take the instructions collected for the segment just closed.
  task automatic snap(output logic [511:0] ins, output logic [4:0] len);
    ins = acc;
    len = 5'(acc_len);
    acc = '0;
    acc_len = 0;
  endtask

  // Driver: issue one lookup and push the expected response.
  task automatic lookup(input logic [31:0] a, input logic [1:0] p, input exp_t e,
                        input string tag);
    @(negedge clk);
    rt_valid = 1'b0;
    lk_valid = 1'b1;
    lk_addr  = a;
    lk_pred  = p;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  function automatic exp_t miss();
    exp_t e;
    e = '0;
    return e;
  endfunction

  function automatic exp_t hitv(input logic [4:0] l, input logic eb, input logic [31:0] f,
                                input logic [31:0] t, input logic [511:0] ins);
    exp_t e;
    e.hit = 1'b1; e.len = l; e.end_br = eb; e.fall = f; e.tgt = t; e.ins = ins;
    return e;
  endfunction

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: response with no lookup pending, got hit=%0b exp none", rsp_hit);
      end else begin
        exp_t  e;
        exp_t  g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g.hit = rsp_hit; g.len = rsp_len; g.end_br = rsp_end_br;
        g.fall = rsp_fall; g.tgt = rsp_tgt; g.ins = rsp_insns;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: got hit=%0b len=%0d eb=%0b fall=%h tgt=%h ins=%h exp hit=%0b len=%0d eb=%0b fall=%h tgt=%h ins=%h",
                   t, g.hit, g.len, g.end_br, g.fall, g.tgt, g.ins,
                   e.hit, e.len, e.end_br, e.fall, e.tgt, e.ins);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] ins_a, ins_b, ins_c, ins_d;
    logic [4:0]   len_a, len_b, len_c, len_d;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset got valid=%0b hit=%0b exp 0 0", rsp_valid, rsp_hit);
    end
    lookup(32'h100, 2'b01, miss(), "R1 empty table");
    idle(3);

    // Segment A: closes at its third branch (R7), ends on a branch (R8).
    retire(32'h100, 0, 0, 0); retire(32'h101, 0, 0, 0); retire(32'h102, 0, 0, 0);
    retire(32'h103, 0, 0, 0); retire(32'h104, 1, 1, 32'h200);
    retire(32'h200, 0, 0, 0); retire(32'h201, 1, 0, 32'h280);
    retire(32'h202, 0, 0, 0); retire(32'h203, 1, 1, 32'h300);
    snap(ins_a, len_a);
    idle(3);
    lookup(32'h100, 2'b01, hitv(len_a, 1, 32'h204, 32'h300, ins_a), "R7 R8 R5 branch-limited hit");
    lookup(32'h100, 2'b11, miss(), "R4 second flag differs");
    lookup(32'h100, 2'b00, miss(), "R4 first flag differs");
    lookup(32'h140, 2'b01, miss(), "R3 tag mismatch same slot");
    idle(3);

    // Segment B: 16 instructions, one not-taken branch (R6), then C starts (R9).
    for (int i = 0; i < 16; i++)
      retire(32'h400 + i, (i == 5), 0, 32'h999);
    snap(ins_b, len_b);
    retire(32'h410, 1, 1, 32'h500); retire(32'h500, 1, 1, 32'h600);
    retire(32'h600, 1, 1, 32'h700);
    snap(ins_c, len_c);
    idle(3);
    lookup(32'h100, 2'b01, miss(), "R10 displaced start misses");
    lookup(32'h400, 2'b00, hitv(len_b, 0, 32'h410, 32'h410, ins_b), "R6 R8 length-limited hit");
    lookup(32'h400, 2'b10, hitv(len_b, 0, 32'h410, 32'h410, ins_b), "R4 masked bit ignored");
    lookup(32'h400, 2'b01, miss(), "R4 compared bit differs");
    lookup(32'h410, 2'b11, hitv(len_c, 1, 32'h601, 32'h700, ins_c), "R9 next segment starts fresh");
    idle(3);

    // Segment D overwrites B's slot; lookup in the write cycle sees B (R11).
    retire(32'h1100, 0, 0, 0); retire(32'h1101, 1, 1, 32'h1200);
    retire(32'h1200, 1, 1, 32'h1300); retire(32'h1300, 1, 0, 32'h1400);
    snap(ins_d, len_d);
    lookup(32'h400, 2'b00, hitv(len_b, 0, 32'h410, 32'h410, ins_b), "R11 same-cycle old contents");
    lookup(32'h1100, 2'b11, hitv(len_d, 1, 32'h1301, 32'h1400, ins_d), "R8 R10 not-taken final target");
    lookup(32'h400, 2'b00, miss(), "R10 R12 overwritten slot");
    idle(6);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing, exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule